// File: doc/BRIEF.md
# DS1 Superframe Terminal Framing Search

This block finds frame alignment in a superframe-formatted DS1 bit stream. Every bit arrives with a one-cycle enable. The block keeps a 193-position frame counter. For each pair (bit position, frame parity) it records how long that slot has carried a strictly alternating value. That gives 386 candidates, and all of them are qualified at the same time. When a candidate qualifies under the active lock rule, the block re-bases its frame counter on that bit and declares terminal frame sync.

Once in terminal sync, the block checks each terminal framing bit against the expected alternation. It also collects the framing bits of the other frames and looks for the signalling-frame sequence. When that sequence is found, it declares multiframe sync and marks the two signalling frames of each 12-frame superframe. Terminal sync is kept even if the signalling sequence never shows up. Terminal sync is dropped when the recent framing bits contain too many errors, and the search then starts again.

A control input selects between two lock rules. One locks on the first candidate that qualifies. The other refuses to lock while more than one candidate alternates.

Top module: `ds1_sf_framer`

## Requirements
- R1: While reset is held and after it, `tsync_n` and `msync_n` are 1, `sig_frame` is 0 and `frame_pos` is 192, so the first enabled bit is position 0.
- R2: `frame_pos` rises by one for each bit taken with `bit_en` high and wraps from 192 to 0. It holds its value in cycles where `bit_en` is low.
- R3: A candidate is a (position, frame parity) slot. It qualifies when its last 8 samples alternate. With `mimic_allow`=1, the bit that qualifies the first candidate causes the lock. After that bit, `tsync_n` is 0 and `frame_pos` is 0.
- R4: After lock, `frame_pos` gives the distance in bits from the terminal framing bit that was locked.
- R5: With `mimic_allow`=0, a qualified candidate locks at its next sample, provided it is still alternating and is the only qualified candidate at that moment.
- R6: With `mimic_allow`=0, no lock occurs while two candidates are qualified.
- R7: In terminal sync, the framing bits of the non-terminal frames are collected. `msync_n` goes to 0 on the framing bit that completes the sequence 0,0,1,1,1,0 (oldest first). That frame becomes frame 12.
- R8: Terminal sync is kept even when the signalling-frame sequence never appears.
- R9: In multiframe sync, `sig_frame` is 1 during frames 6 and 12 and 0 in all other frames.
- R10: In sync, if 2 of the last 4 terminal framing bits are wrong, `tsync_n` and `msync_n` both return to 1 after that bit. One error in any 4 keeps sync.
- R11: After a loss of sync, the search restarts with all candidates cleared. It relocks on the 8th alternating sample that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Marks a cycle that carries a line bit |
| bit_in | input | 1 | Serial DS1 data bit |
| mimic_allow | input | 1 | 1: lock on the first qualified candidate; 0: reject mimics |
| frame_pos | output | 8 | Position of the last bit taken (0 to 192) |
| tsync_n | output | 1 | Terminal frame sync, 0 = in sync |
| msync_n | output | 1 | Multiframe sync, 0 = in sync |
| sig_frame | output | 1 | High during signalling frames 6 and 12 |

## Verification
All results come from registers that update on the edge where the bit is taken. A lock, a multiframe declaration, a drop or a position step is therefore visible right after the clock edge of that bit, with no added latency. The bench drives each bit on a falling edge and reads the outputs on the next falling edge. It counts the bits it has sent, and it predicts the exact bit index of every event from the framing rules: the 8th or 9th terminal sample, the end of the 6-bit signalling window, and the 2-in-4 error bit. It then checks the status on both sides of that index.

// File: rtl/ds1_sf_pkg.sv
// Package: shared types and constants for the DS1 superframe framer.
// Assumes: the superframe is 12 frames with terminal bits in odd frames.
package ds1_sf_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_TERM  = 2'd1,
        ST_MULTI = 2'd2
    } sync_st_t;

    localparam int          SF_FRAMES = 12;
    localparam int          FS_LEN    = 6;
    // Signalling-frame sequence, oldest bit in the MSB
    localparam logic [5:0]  FS_SEQ    = 6'b001110;

endpackage

// File: rtl/dsf_pos_ctr.sv
// Module: bit position counter within a frame, with frame parity.
// Assumes: one bit per cycle with bit_en high; realign makes the bit
// being taken position 0.
module dsf_pos_ctr #(
    parameter int FRAME_BITS = 193,
    localparam int PW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          realign,
    output logic [PW-1:0] pos_q,
    output logic [PW-1:0] pos_in,
    output logic          par_in,
    output logic          frm_start
);

    localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

    logic par_q;

    // Position and parity of the incoming bit
    always_comb begin
        pos_in    = (pos_q == LAST) ? '0 : pos_q + 1'b1;
        frm_start = (pos_in == '0);
        par_in    = frm_start ? ~par_q : par_q;
    end

    // Advance the counter on each bit taken, re-basing it on a lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= LAST;
            par_q <= 1'b1;
        end else if (bit_en) begin
            pos_q <= realign ? '0 : pos_in;
            par_q <= par_in;
        end
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) pos_q <= LAST); // R2
    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bit_en |=> $stable(pos_q)); // R2

endmodule

// File: rtl/dsf_cand.sv
// Module: candidate table. For each (parity, position) slot it keeps
// the last value and the length of the alternating run, and it keeps a
// running count of qualified slots.
// Assumes: upd is high only while searching; clr empties the table.
module dsf_cand #(
    parameter int FRAME_BITS = 193,
    parameter int QUAL_RUN   = 8,
    localparam int PW = $clog2(FRAME_BITS),
    localparam int NCAND = 2 * FRAME_BITS,
    localparam int CW = $clog2(NCAND + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          clr,
    input  logic          bit_in,
    input  logic          par_in,
    input  logic [PW-1:0] pos_in,
    output logic          now_q,
    output logic          was_q,
    output logic [CW-1:0] qual_total
);

    localparam int IW = $clog2(NCAND);
    localparam int RW = $clog2(QUAL_RUN + 1);
    localparam logic [RW-1:0] RUN_FULL = RW'(QUAL_RUN);

    logic [RW-1:0]    run_q [NCAND];
    logic [NCAND-1:0] last_q;
    logic [CW-1:0]    qual_q;
    logic [IW-1:0]    idx;
    logic [RW-1:0]    run_cur, run_nxt;
    logic             last_cur;

    // Work out the slot's new run length and the new qualified total
    always_comb begin
        idx      = par_in ? IW'(pos_in) + IW'(FRAME_BITS) : IW'(pos_in);
        run_cur  = run_q[idx];
        last_cur = last_q[idx];
        if (run_cur != '0 && bit_in != last_cur)
            run_nxt = (run_cur == RUN_FULL) ? run_cur : run_cur + 1'b1;
        else
            run_nxt = RW'(1);
        was_q      = (run_cur == RUN_FULL);
        now_q      = (run_nxt == RUN_FULL);
        qual_total = qual_q + CW'(now_q) - CW'(was_q);
    end

    // Store the slot update, or empty the table
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < NCAND; i++) run_q[i] <= '0;
            last_q <= '0;
            qual_q <= '0;
        end else if (upd) begin
            run_q[idx]  <= run_nxt;
            last_q[idx] <= bit_in;
            qual_q      <= qual_total;
        end
    end

    AST_QUAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) qual_q <= CW'(NCAND)); // R6
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) clr |=> qual_q == '0); // R11

endmodule

// File: rtl/dsf_sync.sv
// Module: sync state machine. It locks on a candidate, checks the
// terminal bits, searches for the signalling sequence and tracks the
// frame number.
// Assumes: frm_start marks the bit at position 0; candidate flags are
// valid in the same cycle.
module dsf_sync
    import ds1_sf_pkg::*;
#(
    parameter int CW      = 9,
    parameter int ERR_WIN = 4,
    parameter int ERR_MAX = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          bit_in,
    input  logic          frm_start,
    input  logic          mimic_allow,
    input  logic          now_q,
    input  logic          was_q,
    input  logic [CW-1:0] qual_total,
    output logic          lock_hit,
    output logic          searching,
    output logic          tsync_n,
    output logic          msync_n,
    output logic          sig_frame
);

    sync_st_t           st_q;
    logic [3:0]         fnum_q, fnum_in;
    logic               exp_ft_q;
    logic [ERR_WIN-1:0] err_hist_q, hist_nxt;
    logic [FS_LEN-1:0]  fs_hist_q, fs_win;
    logic               ft_slot, fs_slot, drop, fs_hit;

    // Lock rule, slot decode and error window
    always_comb begin
        searching = (st_q == ST_HUNT);
        lock_hit  = searching && (mimic_allow ? now_q
                                  : (now_q && was_q && qual_total == CW'(1)));
        fnum_in   = frm_start ? ((fnum_q == 4'(SF_FRAMES)) ? 4'd1 : fnum_q + 4'd1)
                              : fnum_q;
        ft_slot   = frm_start && fnum_in[0];
        fs_slot   = frm_start && !fnum_in[0];
        hist_nxt  = {err_hist_q[ERR_WIN-2:0], bit_in != exp_ft_q};
        drop      = ft_slot && ($countones(hist_nxt) >= ERR_MAX);
        fs_win    = {fs_hist_q[FS_LEN-2:0], bit_in};
        fs_hit    = fs_slot && (st_q == ST_TERM) && (fs_win == FS_SEQ);
    end

    // State, frame number and framing-bit history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_HUNT;
            fnum_q     <= 4'(SF_FRAMES);
            exp_ft_q   <= 1'b0;
            err_hist_q <= '0;
            fs_hist_q  <= '1;
        end else if (bit_en) begin
            if (st_q == ST_HUNT) begin
                if (lock_hit) begin
                    st_q       <= ST_TERM;
                    fnum_q     <= 4'd1;
                    exp_ft_q   <= ~bit_in;
                    err_hist_q <= '0;
                    fs_hist_q  <= '1;
                end
            end else begin
                fnum_q <= fnum_in;
                if (ft_slot) begin
                    exp_ft_q   <= ~exp_ft_q;
                    err_hist_q <= hist_nxt;
                    if (drop) st_q <= ST_HUNT;
                end
                if (fs_slot) begin
                    fs_hist_q <= fs_win;
                    if (fs_hit) begin
                        st_q   <= ST_MULTI;
                        fnum_q <= 4'(SF_FRAMES);
                    end
                end
            end
        end
    end

    // Active-low status and signalling-frame marker
    always_comb begin
        tsync_n   = (st_q == ST_HUNT);
        msync_n   = (st_q != ST_MULTI);
        sig_frame = (st_q == ST_MULTI) && (fnum_q == 4'd6 || fnum_q == 4'd12);
    end

    AST_MULTI_AFTER_TERM: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_MULTI) |-> ($past(st_q) != ST_HUNT)); // R7
    AST_FNUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (fnum_q >= 4'd1 && fnum_q <= 4'd12)); // R9
    AST_SIG_NEEDS_MULTI: assert property (@(posedge clk) disable iff (!rst_n) sig_frame |-> !msync_n); // R9
    AST_DROP_ON_FBIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(tsync_n) |-> $past(bit_en && frm_start)); // R10

endmodule

// File: rtl/ds1_sf_framer.sv
// Module: top of the DS1 superframe framer. It wires the position
// counter, the candidate table and the sync state machine together.
// Assumes: one serial bit per enabled cycle and a synchronous reset.
module ds1_sf_framer #(
    parameter int FRAME_BITS = 193,
    parameter int QUAL_RUN   = 8,
    parameter int ERR_WIN    = 4,
    parameter int ERR_MAX    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_en,
    input  logic                          bit_in,
    input  logic                          mimic_allow,
    output logic [$clog2(FRAME_BITS)-1:0] frame_pos,
    output logic                          tsync_n,
    output logic                          msync_n,
    output logic                          sig_frame
);

    localparam int PW = $clog2(FRAME_BITS);
    localparam int CW = $clog2(2 * FRAME_BITS + 1);

    logic [PW-1:0] pos_in;
    logic          par_in, frm_start;
    logic          now_q, was_q, lock_hit, searching;
    logic [CW-1:0] qual_total;

    dsf_pos_ctr #(.FRAME_BITS(FRAME_BITS)) u_pos (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .realign(lock_hit),
        .pos_q(frame_pos), .pos_in(pos_in), .par_in(par_in), .frm_start(frm_start)
    );

    dsf_cand #(.FRAME_BITS(FRAME_BITS), .QUAL_RUN(QUAL_RUN)) u_cand (
        .clk(clk), .rst_n(rst_n), .upd(bit_en && searching), .clr(!searching),
        .bit_in(bit_in), .par_in(par_in), .pos_in(pos_in),
        .now_q(now_q), .was_q(was_q), .qual_total(qual_total)
    );

    dsf_sync #(.CW(CW), .ERR_WIN(ERR_WIN), .ERR_MAX(ERR_MAX)) u_sync (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .frm_start(frm_start), .mimic_allow(mimic_allow),
        .now_q(now_q), .was_q(was_q), .qual_total(qual_total),
        .lock_hit(lock_hit), .searching(searching),
        .tsync_n(tsync_n), .msync_n(msync_n), .sig_frame(sig_frame)
    );

    AST_LOCK_AT_FBIT: assert property (@(posedge clk) disable iff (!rst_n) $fell(tsync_n) |-> frame_pos == '0); // R3
    AST_MSYNC_NEEDS_TSYNC: assert property (@(posedge clk) disable iff (!rst_n) !msync_n |-> !tsync_n); // R8

endmodule

// File: tb/tb_ds1_sf_framer.sv
`timescale 1ns/1ps
module tb_ds1_sf_framer;

    localparam int FB = 193;
    localparam int MIM_POS = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       mimic_allow = 1'b1;
    logic [7:0] frame_pos;
    logic       tsync_n, msync_n, sig_frame;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Transmitter model state
    int idx, fa, tp, mim_stop, start_off;
    int errf[4];
    bit fs_kill, mim_en;
    logic mim_val;

    always #2.5 clk = ~clk;

    ds1_sf_framer dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .mimic_allow(mimic_allow), .frame_pos(frame_pos),
        .tsync_n(tsync_n), .msync_n(msync_n), .sig_frame(sig_frame)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (bit %0d)", req, act, exp, idx - 1);
        end
    endtask

    task automatic do_reset();
        bit_en = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
    endtask

    task automatic start_stream(input int s);
        fa = 1; tp = s; idx = 0; start_off = s; mim_val = 1'b1;
        for (int i = 0; i < 4; i++) errf[i] = -1;
    endtask

    // Stream index of (frame f, position p) in the current stream
    function automatic int ix(input int f, input int p);
        return (f - 1) * FB + p - start_off;
    endfunction

    task automatic gen_bit(output logic b);
        int sf;
        sf = ((fa - 1) % 12) + 1;
        if (tp == 0) begin
            if (sf % 2 == 1) begin
                b = (sf % 4 == 1);
                for (int i = 0; i < 4; i++) if (errf[i] == fa) b = ~b;
            end else if (fs_kill) b = 1'b1;
            else b = (sf == 6 || sf == 8 || sf == 10);
        end else if (mim_en && tp == MIM_POS && (fa % 2 == 1)) begin
            if (fa < mim_stop) begin b = mim_val; mim_val = ~mim_val; end
            else b = ~mim_val;
        end else begin
            b = logic'(((tp ^ (tp >> 2)) & 1) != 0);
        end
        if (tp == FB - 1) begin tp = 0; fa++; end
        else tp++;
    endtask

    task automatic send1();
        logic b;
        gen_bit(b);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        idx++;
    endtask

    task automatic run_to(input int n);
        while (idx <= n) send1();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 frame_pos in reset", frame_pos, 192);
        chk("R1 tsync_n in reset", tsync_n, 1);
        do_reset();
        chk("R1 frame_pos after reset", frame_pos, 192);
        chk("R1 tsync_n after reset", tsync_n, 1);
        chk("R1 msync_n after reset", msync_n, 1);
        chk("R1 sig_frame after reset", sig_frame, 0);
    endtask

    // Clean stream, first-qualify lock, multiframe, error drop, relock
    task automatic t_clean_allow();
        mimic_allow = 1'b1; fs_kill = 0; mim_en = 0;
        do_reset(); start_stream(0);
        run_to(0);
        chk("R2 first bit position", frame_pos, 0);
        run_to(ix(15, 0) - 1);
        chk("R3 no lock before 8th sample", tsync_n, 1);
        run_to(ix(15, 0));
        chk("R3 lock on 8th sample", tsync_n, 0);
        chk("R3 position zero at lock", frame_pos, 0);
        repeat (5) @(negedge clk);
        chk("R2 hold with bit_en low", frame_pos, 0);
        run_to(ix(15, 57));
        chk("R4 distance from locked bit", frame_pos, 57);
        run_to(ix(16, 0) - 1);
        chk("R2 last position", frame_pos, 192);
        run_to(ix(16, 0));
        chk("R2 wrap to zero", frame_pos, 0);
        run_to(ix(36, 0) - 1);
        chk("R7 no multiframe before sequence", msync_n, 1);
        run_to(ix(36, 0));
        chk("R7 multiframe on sequence end", msync_n, 0);
        chk("R9 frame 12 marked", sig_frame, 1);
        run_to(ix(37, 0) - 1);
        chk("R9 marker through frame 12", sig_frame, 1);
        run_to(ix(37, 0));
        chk("R9 frame 1 unmarked", sig_frame, 0);
        run_to(ix(42, 0));
        chk("R9 frame 6 marked", sig_frame, 1);
        errf[0] = 51; errf[1] = 59;
        run_to(ix(61, 0) - 1);
        chk("R10 single errors keep sync", tsync_n, 0);
        errf[2] = 69; errf[3] = 75;
        run_to(ix(75, 0) - 1);
        chk("R10 still in sync before second error", tsync_n, 0);
        run_to(ix(75, 0));
        chk("R10 drop tsync on 2 in 4", tsync_n, 1);
        chk("R10 drop msync on 2 in 4", msync_n, 1);
        run_to(ix(91, 0) - 1);
        chk("R11 no relock before 8th sample", tsync_n, 1);
        run_to(ix(91, 0));
        chk("R11 relock after restart", tsync_n, 0);
        chk("R11 position zero at relock", frame_pos, 0);
    endtask

    task automatic t_no_fs();
        mimic_allow = 1'b1; fs_kill = 1; mim_en = 0;
        do_reset(); start_stream(0);
        run_to(ix(15, 0));
        chk("R8 terminal lock without sequence", tsync_n, 0);
        run_to(ix(41, 0));
        chk("R8 terminal sync kept", tsync_n, 0);
        chk("R8 no multiframe", msync_n, 1);
        fs_kill = 0;
    endtask

    task automatic t_clean_reject();
        mimic_allow = 1'b0; fs_kill = 0; mim_en = 0;
        do_reset(); start_stream(0);
        run_to(ix(15, 0));
        chk("R5 no lock on qualifying sample", tsync_n, 1);
        run_to(ix(17, 0) - 1);
        chk("R5 no lock before confirm", tsync_n, 1);
        run_to(ix(17, 0));
        chk("R5 lock on confirm sample", tsync_n, 0);
        chk("R5 position zero at lock", frame_pos, 0);
    endtask

    task automatic t_mimic_allow();
        mimic_allow = 1'b1; fs_kill = 0; mim_en = 1; mim_stop = 1000;
        do_reset(); start_stream(60);
        run_to(ix(15, MIM_POS) - 1);
        chk("R3 no lock before mimic qualifies", tsync_n, 1);
        run_to(ix(15, MIM_POS));
        chk("R3 lock on first qualified", tsync_n, 0);
        chk("R3 position zero on mimic", frame_pos, 0);
        run_to(ix(15, MIM_POS + 20));
        chk("R4 distance from mimic bit", frame_pos, 20);
    endtask

    task automatic t_mimic_reject();
        mimic_allow = 1'b0; fs_kill = 0; mim_en = 1; mim_stop = 41;
        do_reset(); start_stream(60);
        run_to(ix(25, 0));
        chk("R6 two candidates, no lock", tsync_n, 1);
        run_to(ix(43, 0) - 1);
        chk("R6 no lock until mimic breaks", tsync_n, 1);
        run_to(ix(43, 0));
        chk("R5 lock once sole candidate", tsync_n, 0);
        chk("R5 lock on true position", frame_pos, 0);
        mim_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        fs_kill = 0; mim_en = 0; mim_stop = 1000;
        start_stream(0);
        @(negedge clk);
        t_reset();
        t_clean_allow();
        t_no_fs();
        t_clean_reject();
        t_mimic_allow();
        t_mimic_reject();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule